// File: doc/BRIEF.md
# Continuous read mode controller

This block is the front end of a serial flash slave for multi-line fast reads. When a frame starts, an opcode arrives one bit per clock on IO0. A dual or quad read command follows. The block then collects a 24-bit start address and an 8-bit mode byte over two or four lines. It waits out the dummy clocks of the command and then streams bytes from a synchronous memory read port back over the same lines. The stream continues until chip select rises.

The mode byte decides how the next frame begins. An upper nibble of 0xA keeps the block in continuous mode: the next frame skips the opcode and starts with the address, using the same command. Any other value returns the block to opcode decoding. A frame that holds IO0 high for its whole address and mode phase cancels continuous mode. All logic runs on the serial clock, and a synchronous active-high reset returns the block to opcode decoding.

Top module: `cont_read_ctrl`

## Requirements
- R1: After reset, io_oe is 0, mem_rd is 0 and continuous mode is off, so the first frame is decoded as an opcode.
- R2: In opcode decoding, the first 8 clocks of a frame carry an opcode on io_in[0], MSB first. 0xBB selects dual read, 0xEB selects quad read and 0xE7 selects word-aligned quad read. Any other opcode makes the rest of the frame ignored, and io_oe stays 0.
- R3: Dual read: address bits A23..A0 and then mode bits M7..M0 arrive two per clock on io_in[1:0], higher bit on io_in[1], MSB first, over 16 clocks. There are no dummy clocks. Data leaves on io_out[1:0] two bits per clock, MSB first, with io_oe = 4'b0011.
- R4: Quad read: address and mode arrive four bits per clock on io_in[3:0], MSB first, over 8 clocks. 4 dummy clocks follow. Data leaves on io_out[3:0] four bits per clock, high nibble first, with io_oe = 4'b1111.
- R5: Word-aligned quad read uses the quad lane format with 2 dummy clocks. Address bits [3:0] are taken as zero whatever was sent.
- R6: The quad and word-aligned quad opcodes are ignored while quad_en is 0.
- R7: A mode byte whose upper nibble is 0xA makes the next frame start with the address in the same command format, with no opcode. Any other mode byte makes the next frame start with an opcode.
- R8: In continuous mode, a frame that holds io_in[0] at 1 on every address and mode clock returns no data and turns continuous mode off. The opcode 0xFF in opcode decoding returns no data and leaves continuous mode off.
- R9: io_oe is 0 during the opcode, address, mode and dummy clocks. The first data bits and the enables appear in the cycle after the last mode or dummy clock.
- R10: The read address increments by one per byte and wraps at 24 bits. Data continues until cs_n rises.
- R11: After any clock edge with cs_n high, io_oe is 0 and the frame is abandoned.
- R12: mem_rd is a one-cycle pulse with mem_addr valid. The memory returns mem_data one cycle later and holds it until the next read. mem_rd is issued only in cycles that follow an edge with cs_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled and outputs updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select framing each transaction |
| io_in | input | 4 | Values seen on the four I/O lines |
| io_out | output | 4 | Values driven onto the I/O lines in the data phase |
| io_oe | output | 4 | Per-line output enable |
| quad_en | input | 1 | Quad enable bit from the status register |
| mem_rd | output | 1 | Read strobe to the memory |
| mem_addr | output | 24 | Byte address of the read |
| mem_data | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
In a dual read the final mode clock is the same edge that decides continuation and, because dual read has no dummy clocks, the same edge that loads the first data byte and raises the enables. The mode-reset pattern also lands on that edge and must suppress the load. Dual frames ending with a 0xA upper nibble, with another nibble, and with IO0 held high are run back to back. Each is judged twice: by io_oe and the first data bits in the very next cycle, and by whether the following frame is accepted without an opcode.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [1:0] {K_DUAL, K_QUAD, K_WORD} kind_t;
  typedef enum logic [2:0] {S_OPC, S_ADR, S_DUM, S_DAT, S_IGN} state_t;
endpackage

// File: rtl/crm_in_shift.sv
module crm_in_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         one,
  input  logic         quad,
  input  logic [3:0]   io,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  always_comb begin
    if (one)       nxt = {q[W-2:0], io[0]};
    else if (quad) nxt = {q[W-5:0], io};
    else           nxt = {q[W-3:0], io[1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/crm_out_shift.sv
module crm_out_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic          shift,
  input  logic          quad,
  input  logic [DW-1:0] din,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe
);
  logic [DW-1:0] sh_q;
  logic          quad_q;
  logic          on_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q   <= '0;
      quad_q <= 1'b0;
      on_q   <= 1'b0;
    end else if (load) begin
      sh_q   <= din;
      quad_q <= quad;
      on_q   <= 1'b1;
    end else if (shift) begin
      sh_q <= quad_q ? (sh_q << 4) : (sh_q << 2);
    end
  end

  always_comb begin
    io_oe  = on_q ? (quad_q ? 4'hF : 4'h3) : 4'h0;
    io_out = 4'h0;
    if (on_q) io_out = quad_q ? sh_q[DW-1 -: 4] : {2'b00, sh_q[DW-1 -: 2]};
  end
endmodule

// File: rtl/cont_read_ctrl.sv
module cont_read_ctrl
  import crm_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         MODE_W     = 8,
  parameter int         DATA_W     = 8,
  parameter int         ALIGN_W    = 4,
  parameter int         DUMMY_DUAL = 0,
  parameter int         DUMMY_QUAD = 4,
  parameter int         DUMMY_WORD = 2,
  parameter logic [7:0] OP_DUAL    = 8'hBB,
  parameter logic [7:0] OP_QUAD    = 8'hEB,
  parameter logic [7:0] OP_WORD    = 8'hE7,
  parameter logic [3:0] CONT_NIB   = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic              quad_en,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int OPC_W   = 8;
  localparam int AMW     = ADDR_W + MODE_W;
  localparam int AM_CK_D = AMW / 2;
  localparam int AM_CK_Q = AMW / 4;
  localparam int A_CK_D  = ADDR_W / 2;
  localparam int A_CK_Q  = ADDR_W / 4;
  localparam int B_CK_D  = DATA_W / 2;
  localparam int B_CK_Q  = DATA_W / 4;
  localparam int CW      = $clog2(AM_CK_D + DUMMY_DUAL + DUMMY_QUAD + DUMMY_WORD + OPC_W) + 1;

  state_t          st_q;
  kind_t           kind_q;
  logic [CW-1:0]   cnt_q;
  logic            cont_q, fr_cont_q, ones_q;
  logic [ADDR_W-1:0] nxt;
  logic            is_quad, at_mlast, mrst_hit, ld, shf;
  logic [CW-1:0]   amlast, alast, blast, dcnt;

  always_comb begin
    is_quad = (kind_q != K_DUAL);
    amlast  = is_quad ? CW'(AM_CK_Q - 1) : CW'(AM_CK_D - 1);
    alast   = is_quad ? CW'(A_CK_Q - 1)  : CW'(A_CK_D - 1);
    blast   = is_quad ? CW'(B_CK_Q - 1)  : CW'(B_CK_D - 1);
    case (kind_q)
      K_QUAD:  dcnt = CW'(DUMMY_QUAD);
      K_WORD:  dcnt = CW'(DUMMY_WORD);
      default: dcnt = CW'(DUMMY_DUAL);
    endcase
    at_mlast = (st_q == S_ADR) && (cnt_q == amlast);
    mrst_hit = fr_cont_q && ones_q && io_in[0];
    ld  = !cs_n && ((at_mlast && !mrst_hit && dcnt == '0) ||
                    (st_q == S_DUM && cnt_q == dcnt - CW'(1)) ||
                    (st_q == S_DAT && cnt_q == blast));
    shf = !cs_n && (st_q == S_DAT) && (cnt_q != blast);
  end

  crm_in_shift #(.W(ADDR_W)) i_in (
    .clk(clk), .rst(rst), .en(!cs_n), .one(st_q == S_OPC), .quad(is_quad),
    .io(io_in), .nxt(nxt)
  );

  crm_out_shift #(.DW(DATA_W)) i_out (
    .clk(clk), .rst(rst), .clr(cs_n), .load(ld), .shift(shf), .quad(is_quad),
    .din(mem_data), .io_out(io_out), .io_oe(io_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_OPC;
      kind_q    <= K_DUAL;
      cnt_q     <= '0;
      cont_q    <= 1'b0;
      fr_cont_q <= 1'b0;
      ones_q    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_rd <= 1'b0;
      if (cs_n) begin
        st_q      <= cont_q ? S_ADR : S_OPC;
        cnt_q     <= '0;
        fr_cont_q <= cont_q;
        ones_q    <= 1'b1;
      end else begin
        case (st_q)
          S_OPC: begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(OPC_W - 1)) begin
              cnt_q <= '0;
              if (nxt[OPC_W-1:0] == OP_DUAL) begin
                kind_q <= K_DUAL; st_q <= S_ADR;
              end else if (nxt[OPC_W-1:0] == OP_QUAD && quad_en) begin
                kind_q <= K_QUAD; st_q <= S_ADR;
              end else if (nxt[OPC_W-1:0] == OP_WORD && quad_en) begin
                kind_q <= K_WORD; st_q <= S_ADR;
              end else begin
                st_q <= S_IGN;
              end
            end
          end
          S_ADR: begin
            cnt_q  <= cnt_q + CW'(1);
            ones_q <= ones_q & io_in[0];
            if (cnt_q == alast) begin
              mem_rd   <= 1'b1;
              mem_addr <= (kind_q == K_WORD) ? {nxt[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}} : nxt;
            end
            if (at_mlast) begin
              cnt_q <= '0;
              if (mrst_hit) begin
                cont_q <= 1'b0;
                st_q   <= S_IGN;
              end else begin
                cont_q <= (nxt[MODE_W-1 -: 4] == CONT_NIB);
                st_q   <= (dcnt == '0) ? S_DAT : S_DUM;
              end
            end
          end
          S_DUM: begin
            if (cnt_q == dcnt - CW'(1)) begin
              cnt_q <= '0;
              st_q  <= S_DAT;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          S_DAT: cnt_q <= (cnt_q == blast) ? '0 : cnt_q + CW'(1);
          default: ;
        endcase
        if (ld) begin
          mem_rd   <= 1'b1;
          mem_addr <= mem_addr + ADDR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/crm_chk.sv
module crm_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [3:0]        io_oe,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r11_cs_release: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (io_oe == 4'h0));

  a_r9_oe_shape: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'h0) || (io_oe == 4'h3) || (io_oe == 4'hF));

  a_r10_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && io_oe != 4'h0) |-> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))));

  a_r12_rd_in_frame: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> $past(!cs_n));
endmodule

bind cont_read_ctrl crm_chk #(.ADDR_W(ADDR_W)) i_crm_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .io_oe(io_oe), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/test_cont_read_ctrl.sv
module test_cont_read_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic [3:0]  io_in = 4'h0;
  logic [3:0]  io_out, io_oe;
  logic        quad_en = 1'b0;
  logic        mem_rd;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data = 8'h00;

  int nchk = 0;
  int nerr = 0;
  logic [3:0] s_out, s_oe, post_oe;
  logic [7:0] got [0:7];
  int oe_setup_bad, oe_data_bad, oe_any;

  // kind(2: 0 dual,1 quad,2 word) | opcode sent | address | mode
  localparam logic [34:0] VEC [0:8] = '{
    {2'd0, 1'b1, 24'h000010, 8'h00},
    {2'd0, 1'b1, 24'h123456, 8'hA5},
    {2'd0, 1'b0, 24'h00ABCD, 8'hA0},
    {2'd0, 1'b0, 24'h7FFFFE, 8'h20},
    {2'd1, 1'b1, 24'h400000, 8'hAF},
    {2'd1, 1'b0, 24'h0F0F03, 8'h5A},
    {2'd2, 1'b1, 24'h23456B, 8'hA3},
    {2'd2, 1'b0, 24'hFFFFF7, 8'h00},
    {2'd0, 1'b1, 24'hFFFFFF, 8'h00}
  };

  cont_read_ctrl i_cont_read_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .quad_en(quad_en), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= pat(mem_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] v, input logic csv);
    @(negedge clk);
    s_out = io_out;
    s_oe  = io_oe;
    io_in = v;
    cs_n  = csv;
  endtask

  function automatic logic [7:0] opc_of(input int kind);
    return (kind == 0) ? 8'hBB : (kind == 1) ? 8'hEB : 8'hE7;
  endfunction

  task automatic run_frame(input int kind, input bit has_op, input logic [7:0] opc,
                           input logic [23:0] a, input logic [7:0] m, input bit ones, input int nb);
    int w = (kind == 0) ? 2 : 4;
    int p = 8 / w;
    int d = (kind == 0) ? 0 : (kind == 1) ? 4 : 2;
    logic [31:0] am = {a, m};
    logic [3:0] emask = (w == 2) ? 4'h3 : 4'hF;
    logic [3:0] v;
    oe_setup_bad = 0; oe_data_bad = 0; oe_any = 0;
    if (has_op)
      for (int i = 0; i < 8; i++) begin
        step({3'b000, opc[7-i]}, 1'b0);
        if (s_oe != 4'h0) oe_setup_bad++;
      end
    for (int i = 0; i < 32 / w; i++) begin
      if (w == 2) v = {2'b00, am[31-2*i -: 2]};
      else        v = am[31-4*i -: 4];
      if (ones) v = 4'hF;
      step(v, 1'b0);
      if (s_oe != 4'h0) oe_setup_bad++;
    end
    for (int i = 0; i < d; i++) begin
      step(4'h0, 1'b0);
      if (s_oe != 4'h0) oe_setup_bad++;
    end
    for (int k = 0; k < nb * p; k++) begin
      step(4'h0, 1'b0);
      if (s_oe != 4'h0) oe_any++;
      if (s_oe != emask) oe_data_bad++;
      if (w == 4) got[k/p] = {got[k/p][3:0], s_out};
      else        got[k/p] = {got[k/p][5:0], s_out[1:0]};
    end
    step(4'h0, 1'b1);
    step(4'h0, 1'b1);
    post_oe = s_oe;
  endtask

  task automatic check_data(input int kind, input logic [23:0] a, input int nb, input string tag);
    logic [23:0] base = (kind == 2) ? {a[23:4], 4'h0} : a;
    for (int j = 0; j < nb; j++)
      check(got[j] == pat(base + 24'(j)), tag, {24'h0, got[j]}, {24'h0, pat(base + 24'(j))});
    check(oe_setup_bad == 0, "R9 quiet before data", oe_setup_bad, 0);
    check(oe_data_bad == 0, "R9 enables in data phase", oe_data_bad, 0);
  endtask

  task automatic check_quiet(input string tag);
    check(oe_setup_bad + oe_any == 0, tag, oe_setup_bad + oe_any, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(io_oe == 4'h0, "R1 reset io_oe", io_oe, 0);
    check(mem_rd == 1'b0, "R1 reset mem_rd", mem_rd, 0);
    // R1: continuous mode off, an opcode-less frame is not read
    run_frame(0, 1'b0, 8'h00, 24'h123456, 8'hA5, 1'b0, 2);
    check_quiet("R1 frame without opcode after reset");
    // R2: unknown opcode
    run_frame(0, 1'b1, 8'h3B, 24'h000020, 8'h00, 1'b0, 2);
    check_quiet("R2 unknown opcode ignored");
    // R6: quad commands with quad_en low
    run_frame(1, 1'b1, 8'hEB, 24'h000100, 8'h00, 1'b0, 2);
    check_quiet("R6 quad read without quad_en");
    run_frame(2, 1'b1, 8'hE7, 24'h000100, 8'h00, 1'b0, 2);
    check_quiet("R6 word read without quad_en");
    quad_en = 1'b1;

    for (int i = 0; i < 9; i++) begin
      logic [34:0] v;
      int kind;
      string tag;
      v = VEC[i];
      kind = int'(v[34:33]);
      tag = (kind == 0) ? "R3" : (kind == 1) ? "R4" : "R5";
      if (!v[32]) tag = {tag, " R7"};
      tag = {tag, " R10 R12 data"};
      run_frame(kind, v[32], opc_of(kind), v[31:8], v[7:0], 1'b0, 3);
      check_data(kind, v[31:8], 3, tag);
      check(post_oe == 4'h0, "R11 release after cs_n high", post_oe, 0);
    end

    // R8: mode reset pattern in dual continuous mode
    run_frame(0, 1'b1, 8'hBB, 24'h000100, 8'hA7, 1'b0, 2);
    check_data(0, 24'h000100, 2, "R7 dual enter continuous");
    run_frame(0, 1'b0, 8'h00, 24'h000000, 8'h00, 1'b1, 2);
    check_quiet("R8 dual reset pattern returns no data");
    run_frame(0, 1'b0, 8'h00, 24'h123456, 8'hA5, 1'b0, 2);
    check_quiet("R8 continuous mode off after reset pattern");
    // R8: reset opcode in opcode decoding
    run_frame(0, 1'b1, 8'hFF, 24'hFFFFFF, 8'hFF, 1'b0, 2);
    check_quiet("R8 reset opcode returns no data");
    run_frame(1, 1'b1, 8'hEB, 24'h000040, 8'h00, 1'b0, 2);
    check_data(1, 24'h000040, 2, "R8 R4 read after reset opcode");
    // R8: quad continuous then reset pattern
    run_frame(1, 1'b1, 8'hEB, 24'h3000A0, 8'hA0, 1'b0, 2);
    check_data(1, 24'h3000A0, 2, "R7 quad enter continuous");
    run_frame(1, 1'b0, 8'h00, 24'h000000, 8'h00, 1'b1, 2);
    check_quiet("R8 quad reset pattern returns no data");
    run_frame(1, 1'b1, 8'hEB, 24'h0000C8, 8'h00, 1'b0, 1);
    check_data(1, 24'h0000C8, 1, "R8 R4 opcode needed after reset pattern");
    check(post_oe == 4'h0, "R11 release mid byte", post_oe, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule